// File: doc/BRIEF.md
# Segment Identifier Scrambler

This block turns a context number and a 64-bit effective address into a scrambled virtual segment identifier. It first builds a proto-identifier by placing the context above the segment index taken from the address. It then multiplies that value by a fixed 24-bit prime and reduces the product modulo a Mersenne number (2^n - 1). The reduction uses one fold addition and one carry correction, so no divider is needed. Because the multiplier is co-prime to the modulus, the mapping is one-to-one over the identifier space.

Two segment sizes are supported. With 256 MB segments the result is 37 bits wide. With 1 TB segments it is 25 bits wide. A kernel-request flag makes the block derive the context from the address region nibble instead of the context input. The identifier zero is reserved for addresses whose in-region offset is out of range, and such addresses always produce zero. The datapath has a registered multiply stage followed by a registered reduction stage, and a valid flag travels alongside it.

Top module: `vsid_scrambler`

## Requirements
- R1: `valid_o` is high exactly two clock cycles after a cycle in which `valid_i` was sampled high. After reset, `valid_o` and `vsid_o` are 0.
- R2: When `seg_1t_i`=0, the proto-identifier is {context[18:0], ea[45:28]} (37 bits), and `vsid_o` = (proto × 12538073) mod (2^37 − 1).
- R3: When `seg_1t_i`=1, the proto-identifier is (context << 6) OR ea[63:40] (25 bits), `vsid_o` = (proto × 12538073) mod (2^25 − 1), and `vsid_o`[36:25] is 0.
- R4: When `kernel_i`=1, `ctx_i` is ignored and the context becomes (2^19 − 4 + ea[63:60] − 12) mod 2^19. Regions 0xC, 0xD, 0xE and 0xF therefore give 0x7FFFC, 0x7FFFD, 0x7FFFE and 0x7FFFF.
- R5: When ea[59:0] ≥ `limit_i`, `vsid_o` is 0 in either mode. When ea[59:0] = `limit_i` − 1, the normal result is produced.
- R6: A proto-identifier equal to the modulus (all ones in the active width) reduces to 0.
- R7: A new request is accepted in every cycle. Requests issued back to back with alternating segment sizes and kernel flags each produce their own result, in order.
- R8: A valid result never equals the modulus value itself (all ones in the active width).
- R9: While `valid_o` is low, `vsid_o` holds the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| ctx_i | input | 19 | Context number (ignored when kernel_i=1) |
| ea_i | input | 64 | Effective address |
| seg_1t_i | input | 1 | 1 selects 1 TB segments, 0 selects 256 MB segments |
| kernel_i | input | 1 | Derive the context from address bits 63:60 |
| limit_i | input | 60 | Exclusive upper bound on the in-region offset ea[59:0] |
| valid_o | output | 1 | Result valid |
| vsid_o | output | 37 | Scrambled segment identifier |

## Verification
Two functions can coincide on a single request: the out-of-range override and the kernel context derivation. The bench provokes this by issuing kernel-region requests whose offset equals the limit exactly, then again at one below the limit. The first case must yield zero and the second the scrambled kernel identifier. A second kind of collision comes from issuing requests back to back that switch segment size between cycles. One result then sits in the reduction stage while the next product enters the multiply stage. Every cycle is compared against a behavioural model that uses the true modulo operator, and this comparison also covers the all-ones proto-identifier case, where the carry correction must wrap the result to zero.

// File: rtl/vsid_pkg.sv
package vsid_pkg;
  localparam int CTX_W        = 19;
  localparam int EA_W         = 64;
  localparam int OFF_W        = 60;
  localparam int REGION_W     = EA_W - OFF_W;
  localparam int SEG_SHIFT    = 28;
  localparam int SEG_SHIFT_1T = 40;
  localparam int ESID_W       = 18;
  localparam int ESID_1T_W    = 6;
  localparam int VSID_W       = CTX_W + ESID_W;
  localparam int VSID_1T_W    = CTX_W + ESID_1T_W;
  localparam int MULT_W       = 24;
  localparam int PROD_W       = 64;
  localparam logic [MULT_W-1:0] MULT = 24'd12538073;
  localparam int KREGION_BASE = 12;
  localparam int KCTX_TOP     = (1 << CTX_W) - 5;

  typedef struct packed {
    logic              valid;
    logic              seg_1t;
    logic              bad;
    logic [PROD_W-1:0] prod;
  } mul_stage_t;
endpackage

// File: rtl/vsid_proto_gen.sv
module vsid_proto_gen
  import vsid_pkg::*;
(
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [EA_W-1:0]   ea_i,
  input  logic              seg_1t_i,
  input  logic              kernel_i,
  input  logic [OFF_W-1:0]  limit_i,
  output logic [VSID_W-1:0] proto_o,
  output logic              bad_o
);
  localparam int HI_EA_W = EA_W - SEG_SHIFT_1T;

  logic [CTX_W-1:0]     ctx_eff;
  logic [CTX_W-1:0]     kctx;
  logic [VSID_W-1:0]    proto_256m;
  logic [VSID_1T_W-1:0] proto_1t;

  // kernel regions take the contexts just above the user range
  assign kctx = CTX_W'(KCTX_TOP + 1) + CTX_W'(ea_i[EA_W-1:OFF_W]) - CTX_W'(KREGION_BASE);
  assign ctx_eff = kernel_i ? kctx : ctx_i;

  assign proto_256m = {ctx_eff, ea_i[SEG_SHIFT+ESID_W-1:SEG_SHIFT]};
  assign proto_1t   = {ctx_eff, {ESID_1T_W{1'b0}}} | VSID_1T_W'(ea_i[EA_W-1:EA_W-HI_EA_W]);

  assign proto_o = seg_1t_i ? VSID_W'(proto_1t) : proto_256m;
  assign bad_o   = ea_i[OFF_W-1:0] >= limit_i;
endmodule

// File: rtl/vsid_mul_stage.sv
module vsid_mul_stage
  import vsid_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              seg_1t_i,
  input  logic              bad_i,
  input  logic [VSID_W-1:0] proto_i,
  output mul_stage_t        stage_o
);
  mul_stage_t stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q.valid <= valid_i;
      if (valid_i) begin
        stage_q.seg_1t <= seg_1t_i;
        stage_q.bad    <= bad_i;
        stage_q.prod   <= PROD_W'(proto_i) * PROD_W'(MULT);
      end
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/vsid_fold_stage.sv
module vsid_fold_stage
  import vsid_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mul_stage_t        stage_i,
  output logic              valid_o,
  output logic [VSID_W-1:0] vsid_o
);
  logic [VSID_W-1:0] res [2];
  logic              valid_q;
  logic              seg_q;
  logic [VSID_W-1:0] vsid_q;

  for (genvar m = 0; m < 2; m++) begin : g_mode
    localparam int N = (m == 1) ? VSID_1T_W : VSID_W;
    localparam logic [PROD_W-1:0] MASK = (PROD_W'(1) << N) - PROD_W'(1);
    logic [PROD_W-1:0] folded;
    logic [PROD_W-1:0] fixed;
    // fold high part onto low part, then absorb the end-around carry
    assign folded = (stage_i.prod >> N) + (stage_i.prod & MASK);
    assign fixed  = folded + ((folded + PROD_W'(1)) >> N);
    assign res[m] = VSID_W'(fixed & MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      seg_q   <= 1'b0;
      vsid_q  <= '0;
    end else begin
      valid_q <= stage_i.valid;
      if (stage_i.valid) begin
        seg_q  <= stage_i.seg_1t;
        vsid_q <= stage_i.bad ? '0 : res[stage_i.seg_1t];
      end
    end
  end

  assign valid_o = valid_q;
  assign vsid_o  = vsid_q;

  assert_not_modulus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (seg_q ? (vsid_q[VSID_1T_W-1:0] != {VSID_1T_W{1'b1}})
                       : (vsid_q != {VSID_W{1'b1}})));
endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler
  import vsid_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [EA_W-1:0]   ea_i,
  input  logic              seg_1t_i,
  input  logic              kernel_i,
  input  logic [OFF_W-1:0]  limit_i,
  output logic              valid_o,
  output logic [VSID_W-1:0] vsid_o
);
  logic [VSID_W-1:0] proto;
  logic              bad;
  mul_stage_t        mul_q;

  vsid_proto_gen u_proto (
    .ctx_i    (ctx_i),
    .ea_i     (ea_i),
    .seg_1t_i (seg_1t_i),
    .kernel_i (kernel_i),
    .limit_i  (limit_i),
    .proto_o  (proto),
    .bad_o    (bad)
  );

  vsid_mul_stage u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .seg_1t_i (seg_1t_i),
    .bad_i    (bad),
    .proto_i  (proto),
    .stage_o  (mul_q)
  );

  vsid_fold_stage u_fold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stage_i (mul_q),
    .valid_o (valid_o),
    .vsid_o  (vsid_o)
  );

  assert_valid_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));

  assert_narrow_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(seg_1t_i, 2)) |-> (vsid_o[VSID_W-1:VSID_1T_W] == '0));

  assert_bad_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(ea_i[OFF_W-1:0] >= limit_i, 2)) |-> (vsid_o == '0));

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(vsid_o));
endmodule

// File: tb/vsid_scrambler_test.sv
module vsid_scrambler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [18:0] ctx_i = '0;
  logic [63:0] ea_i = '0;
  logic        seg_1t_i = 1'b0;
  logic        kernel_i = 1'b0;
  logic [59:0] limit_i = '1;
  logic        valid_o;
  logic [36:0] vsid_o;

  always #4 clk = ~clk;

  vsid_scrambler uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ctx_i(ctx_i), .ea_i(ea_i),
    .seg_1t_i(seg_1t_i), .kernel_i(kernel_i), .limit_i(limit_i),
    .valid_o(valid_o), .vsid_o(vsid_o)
  );

  int    vectors = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_tag = "R1";

  bit          p1_v, p2_v;
  logic [36:0] p1_vsid, p2_vsid, held;
  string       p1_tag, p2_tag;

  function automatic logic [36:0] ref_vsid(bit s1t, bit kern, logic [18:0] c,
                                           logic [63:0] ea, logic [59:0] lim);
    longint unsigned cx, proto, md;
    if (ea[59:0] >= lim) return '0;
    cx = kern ? ((64'd524272 + 64'(ea[63:60])) % 64'd524288) : 64'(c);
    if (s1t) begin
      proto = (cx << 6) | 64'(ea[63:40]);
      md = (64'd1 << 25) - 1;
    end else begin
      proto = (cx << 18) | 64'(ea[45:28]);
      md = (64'd1 << 37) - 1;
    end
    return 37'(((proto % md) * 64'd12538073) % md);
  endfunction

  // behavioural model, two cycles deep
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v = 0; p2_v = 0; held = '0; p1_vsid = '0; p2_vsid = '0;
      p1_tag = "R1"; p2_tag = "R1";
    end else begin
      p2_v = p1_v; p2_vsid = p2_v ? p1_vsid : p2_vsid; p2_tag = p1_tag;
      if (p2_v) held = p2_vsid;
      p1_v = valid_i;
      if (valid_i) begin
        p1_vsid = ref_vsid(seg_1t_i, kernel_i, ctx_i, ea_i, limit_i);
        p1_tag = cur_tag;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (valid_o !== p2_v) begin
        fails++;
        $display("FAIL R1 valid_o actual %0b expected %0b", valid_o, p2_v);
      end else if (vsid_o !== held) begin
        fails++;
        $display("FAIL %s vsid_o actual %h expected %h", p2_v ? p2_tag : "R9", vsid_o, held);
      end
    end
  end

  task automatic send(bit s1t, bit kern, logic [18:0] c, logic [63:0] ea,
                      logic [59:0] lim, string tag);
    @(negedge clk);
    valid_i = 1; seg_1t_i = s1t; kernel_i = kern; ctx_i = c; ea_i = ea;
    limit_i = lim; cur_tag = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 0; ctx_i = 19'h5A5A5; ea_i = {$urandom, $urandom};
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (valid_o !== 1'b0 || vsid_o !== '0) begin
      fails++;
      $display("FAIL R1 reset state actual %0b/%h expected 0/0", valid_o, vsid_o);
    end
    rst_n = 1;
    idle(2);

    // R2: 256 MB directed and random
    send(0, 0, 19'd1, 64'h0000_0000_1000_0000, '1, "R2");
    send(0, 0, 19'd0, 64'h0000_0000_1000_0000, '1, "R2");
    send(0, 0, 19'h12345, 64'h0000_2ABC_D000_0000, '1, "R2");
    for (int i = 0; i < 200; i++) send(0, 0, 19'($urandom), {4'h0, 14'h0, 46'(rnd64())}, '1, "R2");
    idle(3);

    // R3: 1 TB, region bits feed the proto-identifier
    send(1, 0, 19'd1, 64'h0000_0100_0000_0000, '1, "R3");
    send(1, 0, 19'h7FFFF, 64'hFFFF_FF00_0000_0000, '1, "R3");
    for (int i = 0; i < 200; i++) send(1, 0, 19'($urandom), rnd64(), '1, "R3");
    idle(2);

    // R4: kernel contexts in both modes, ctx_i is junk
    for (int r = 12; r < 16; r++) begin
      send(0, 1, 19'($urandom), {4'(r), 60'h0000_1234_5670_000}, '1, "R4");
      send(1, 1, 19'($urandom), {4'(r), 60'h0000_3456_7890_000}, '1, "R4");
    end
    send(0, 1, 19'h0, 64'h3000_0000_0000_0000, '1, "R4");

    // R5: range limit boundary, and coinciding with kernel derivation
    send(0, 0, 19'h00ABC, 64'h0000_1000_0000_0000, 60'h0000_1000_0000_0000, "R5");
    send(0, 0, 19'h00ABC, 64'h0000_0FFF_FFFF_FFFF, 60'h0000_1000_0000_0000, "R5");
    send(1, 0, 19'h00ABC, 64'h0000_2000_0000_0000, 60'h0, "R5");
    send(0, 1, 19'h0, 64'hC000_3FFF_FFFF_FFFF, 60'h0000_3FFF_FFFF_FFFF, "R5");
    send(0, 1, 19'h0, 64'hD000_3FFF_FFFF_FFFE, 60'h0000_3FFF_FFFF_FFFF, "R5");
    send(1, 1, 19'h0, 64'hF000_4000_0000_0000, 60'h0000_4000_0000_0000, "R5");
    idle(1);

    // R6: proto equal to modulus reduces to zero
    send(0, 0, 19'h7FFFF, 64'h0000_3FFF_F000_0000, '1, "R6");
    send(1, 0, 19'h7FFFF, 64'h0000_3F00_0000_0000, '1, "R6");
    idle(2);

    // R7: back to back with alternating modes and kernel flag
    for (int i = 0; i < 300; i++)
      send(1'(i), 1'(i >> 1), 19'($urandom), rnd64(), 60'(rnd64()), "R7");

    // R8 and R9: random proto below modulus with idle gaps
    for (int i = 0; i < 1500; i++) begin
      send(1'($urandom), 0, 19'($urandom), {4'h0, 14'h0, 46'(rnd64())}, '1, "R8");
      if ((i % 7) == 0) idle(1 + (i % 3));
    end
    idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R1 watchdog expired actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule